// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block produces the array address for a synchronous burst memory. On every rising clock edge it can capture a fresh external address when the chip is enabled and either of two address strobes is high. One strobe comes from the processor side and the other from the controller side. When no strobe is accepted, the advance input moves the two lowest address bits to the next beat of a four-beat burst. Without advance the address holds, and that cycle acts as a wait state.

An order input picks the beat sequence. Linear order counts the low bits upward modulo four from the start value. Interleaved order XORs the start value with the beat count. The order is captured together with the address, so one burst keeps one order from start to end. The upper address bits change only on a load. A burst is never required: a new address may be loaded on every clock with no lost cycle. The outputs are the current address and the beat index within the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, addr_out is 0 and beat_idx is 0.
- R2: A strobe (stb_cpu or stb_ctl, either or both) sampled high with chip_en high loads addr_in. After that edge, addr_out equals the sampled addr_in and beat_idx is 0. This holds on consecutive cycles with no gap.
- R3: A strobe sampled while chip_en is low is ignored and loads nothing. That edge behaves as if no strobe were present: it advances if adv is high and holds otherwise.
- R4: When an accepted strobe and adv are sampled high on the same edge, the load takes priority and beat_idx becomes 0.
- R5: adv sampled high with no accepted strobe increments beat_idx modulo 4. After beat 3 it returns to 0, and the low address bits return to the start value.
- R6: In linear order (order_sel = 0 at load), addr_out[1:0] equals (start + beat_idx) mod 4, where start is the loaded addr_in[1:0].
- R7: In interleaved order (order_sel = 1 at load), addr_out[1:0] equals start XOR beat_idx. order_sel is sampled only on a load and has no effect at any other edge.
- R8: With adv low and no accepted strobe, addr_out and beat_idx hold their values (wait state).
- R9: addr_out[ADDR_W-1:2] changes only on a load. Advancing and wrapping never modify it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Qualifies both address strobes |
| stb_cpu | input | 1 | Processor-side address strobe |
| stb_ctl | input | 1 | Controller-side address strobe |
| adv | input | 1 | Step to the next burst beat |
| order_sel | input | 1 | Beat order captured on load: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current array address |
| beat_idx | output | 2 | Beat number within the current burst |

## Verification
The bench builds the sequencer with ADDR_W = 10. A width that small lets random loads repeat upper values often, so a stray change of the upper bits during advances or wraps shows up as a mismatch. It still leaves eight upper bits to expose slips between the upper field and the sequenced field. The random mix keeps many bursts running through all four beats and past the wrap under both orders. Directed cases place every start value, strobe with advance in the same cycle, and a strobe with the chip disabled at known points.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low address bits for a given start value and beat number.
  function automatic logic [BEAT_W-1:0] beat_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input burst_order_e      ord
  );
    if (ord == ORD_INTERLEAVE) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/burst_load_ctrl.sv
module burst_load_ctrl (
  input  logic chip_en,
  input  logic stb_cpu,
  input  logic stb_ctl,
  input  logic adv,
  output logic load_o,
  output logic step_o
);
  logic any_stb;

  always_comb begin
    any_stb = stb_cpu | stb_ctl;
    load_o  = chip_en & any_stb;
    step_o  = adv & ~load_o;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [BEAT_W-1:0] start_i,
  input  burst_order_e      order_i,
  output logic [BEAT_W-1:0] low_o,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  burst_order_e      order_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
      order_q <= ORD_LINEAR;
    end else if (load_i) begin
      start_q <= start_i;
      beat_q  <= '0;
      order_q <= order_i;
    end else if (step_i) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign low_o  = beat_offset(start_q, beat_q, order_q);
  assign beat_o = beat_q;

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> beat_o == $past(beat_o) + 2'd1);

  // R7
  interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && order_q == ORD_INTERLEAVE) |=> (low_o ^ beat_o) == $past(low_o ^ beat_o));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              stb_cpu,
  input  logic              stb_ctl,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat_idx
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic            load_w;
  logic            step_w;
  logic [UP_W-1:0] upper_q;
  logic [BEAT_W-1:0] low_w;
  logic [BEAT_W-1:0] beat_w;
  burst_order_e    order_w;

  assign order_w = order_sel ? ORD_INTERLEAVE : ORD_LINEAR;

  burst_load_ctrl ctrl_i (
    .chip_en (chip_en),
    .stb_cpu (stb_cpu),
    .stb_ctl (stb_ctl),
    .adv     (adv),
    .load_o  (load_w),
    .step_o  (step_w)
  );

  burst_beat_ctr ctr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_w),
    .step_i  (step_w),
    .start_i (addr_in[BEAT_W-1:0]),
    .order_i (order_w),
    .low_o   (low_w),
    .beat_o  (beat_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      upper_q <= '0;
    else if (load_w) upper_q <= addr_in[ADDR_W-1:BEAT_W];
  end

  assign addr_out = {upper_q, low_w};
  assign beat_idx = beat_w;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> (addr_out == $past(addr_in)) && (beat_idx == 2'd0));

  // R3
  disabled_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && !adv) |=> $stable(addr_out) && $stable(beat_idx));

  // R4
  strobe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && (stb_cpu || stb_ctl) && adv) |=> beat_idx == 2'd0);

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_w && !step_w) |=> $stable(addr_out) && $stable(beat_idx));

  // R9
  upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_w |=> $stable(addr_out[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_en = 1'b0;
  logic          stb_cpu = 1'b0;
  logic          stb_ctl = 1'b0;
  logic          adv = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_idx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  logic [AW-3:0] m_up = '0;
  logic [1:0]    m_start = '0;
  logic [1:0]    m_beat = '0;
  logic          m_ilv = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .stb_cpu(stb_cpu),
    .stb_ctl(stb_ctl), .adv(adv), .order_sel(order_sel),
    .addr_in(addr_in), .addr_out(addr_out), .beat_idx(beat_idx)
  );

  function automatic logic [1:0] ref_low(logic [1:0] s, logic [1:0] b, logic ilv);
    int v;
    if (!ilv) begin
      v = (int'(s) + int'(b)) % 4;
      return v[1:0];
    end
    case (b)
      2'd0: return s;
      2'd1: return {s[1], ~s[0]};
      2'd2: return {~s[1], s[0]};
      default: return ~s;
    endcase
  endfunction

  task automatic check(string tag);
    logic [AW-1:0] exp_a;
    exp_a = {m_up, ref_low(m_start, m_beat, m_ilv)};
    checks++;
    if (addr_out !== exp_a || beat_idx !== m_beat) begin
      failures++;
      $display("FAIL %s addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_out, beat_idx, exp_a, m_beat);
    end
  endtask

  // Drive one cycle at the falling edge, update model, check after the rising edge.
  task automatic cyc(logic ce, logic sa, logic sb, logic av, logic ord,
                     logic [AW-1:0] a, string tag);
    @(negedge clk);
    chip_en = ce; stb_cpu = sa; stb_ctl = sb; adv = av; order_sel = ord; addr_in = a;
    if (ce && (sa || sb)) begin
      m_up = a[AW-1:2]; m_start = a[1:0]; m_beat = 2'd0; m_ilv = ord;
    end else if (av) begin
      m_beat = m_beat + 2'd1;
    end
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    string tg;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset");

    // R6: linear burst from start 2, full wrap
    cyc(1, 1, 0, 0, 0, 10'h2A6, "R2 load cpu strobe");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 1, 1, 10'h155, "R6 R5 R9 linear step");
    // R8 wait state
    cyc(1, 0, 0, 0, 1, 10'h3FF, "R8 hold");
    // R7: interleaved from start 3, order_sel toggled mid-burst ignored
    cyc(1, 0, 1, 0, 1, 10'h1B3, "R2 load ctl strobe");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 1, i[0], 10'h000, "R7 R5 interleave step");
    // R4 strobe and advance together
    cyc(1, 1, 1, 1, 0, 10'h0C1, "R4 strobe beats adv");
    // R3 strobe with chip disabled: advances only
    cyc(0, 1, 0, 1, 1, 10'h3C2, "R3 disabled strobe adv");
    cyc(0, 0, 1, 0, 1, 10'h3C2, "R3 disabled strobe hold");
    // R2 back-to-back loads
    for (int s = 0; s < 4; s++)
      cyc(1, 1, 0, 0, s[0], AW'(10'h100 + s * 37), "R2 consecutive load");

    for (int n = 0; n < 4000; n++) begin
      logic ce, sa, sb, av, od;
      logic [AW-1:0] a;
      ce = ($urandom % 8) != 0;
      sa = ($urandom % 5) == 0;
      sb = ($urandom % 6) == 0;
      av = ($urandom % 3) != 0;
      od = $urandom % 2;
      a  = AW'($urandom);
      if (ce && (sa || sb)) tg = av ? "R4 random load+adv" : "R2 random load";
      else if (!ce && (sa || sb)) tg = "R3 random disabled strobe";
      else if (av) tg = m_ilv ? "R7 R9 random step" : "R6 R9 random step";
      else tg = "R8 random hold";
      cyc(ce, sa, sb, av, od, a, tg);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule